// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block turns a single host-side data port into sequential traffic on local packet memory. Software first loads a starting local address and a byte count. Each later port access then reads or writes local memory at the current address. After the access, the address moves forward by the transfer size and the count shrinks by the same amount. When the address reaches the end of the receive ring, it jumps back to the ring's first byte. When the count runs out, the block raises a one-cycle completion request, which the host's interrupt logic can latch.

A port access moves one, two or four bytes. A per-access long flag selects four bytes. Otherwise a static word-mode input chooses between two bytes and one byte. Multi-byte data is stored little-endian. The local map has two regions that can be reached: a 32-byte station-address PROM and a packet memory window set by parameters. An access that does not fit entirely inside one of these regions misses. A read that misses returns all-ones, and a write that misses is dropped. The PROM takes its contents at reset: each of 16 logical bytes is stored twice, in a pair of adjacent addresses. The 16 logical bytes are the six station-address bytes, then zeros, then 0x57 in logical bytes 14 and 15.

Top module: `rdma_port`

## Requirements
- R1: After reset, addr_o and cnt_o are 0 and rvalid_o and done_o are low. The PROM holds its pair-duplicated pattern: logical byte i is at addresses 2i and 2i+1, i=0..5 is STATION_ADDR with its most significant byte first, i=14 and 15 are 0x57, and the rest are 0x00. A reset also undoes any earlier writes to the PROM.
- R2: The transfer size is 4 bytes when long_i=1. Otherwise it is 2 bytes when word_mode_i=1 and 1 byte when word_mode_i=0. Byte k of the access goes at local address eff+k and maps to data bits [8k+7:8k].
- R3: For 2- and 4-byte accesses, the memory address eff is addr_o with bit 0 cleared. The next address is the uncleared addr_o plus the transfer size.
- R4: If the next address equals ring_stop_i, addr_o becomes ring_start_i instead.
- R5: If cnt_o is less than or equal to the transfer size, cnt_o becomes 0 and done_o is high for exactly the next cycle. Otherwise cnt_o drops by the transfer size and done_o stays low.
- R6: A port write while cnt_o is 0 has no effect. Memory, addr_o and cnt_o are all unchanged, and done_o stays low.
- R7: A port read while cnt_o is 0 still proceeds. It returns data, advances addr_o, leaves cnt_o at 0 and pulses done_o.
- R8: An access hits only if all of its bytes lie in [0,32) or in [PMEM_BASE, PMEM_BASE+PMEM_BYTES). A read that misses returns 0xFF, 0xFFFF or 0xFFFFFFFF for its width, with zeros above that width. A write that misses changes no memory. Address and count still update on a miss.
- R9: rdata_o and rvalid_o appear one cycle after a read request. rvalid_o is never high after a write, a load or an idle cycle.
- R10: ld_i sets addr_o to ld_addr_i and cnt_o to ld_cnt_i in the next cycle. A request in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load address and count |
| ld_addr_i | input | AW | Start address to load |
| ld_cnt_i | input | CW | Byte count to load |
| ring_start_i | input | AW | First byte of the ring |
| ring_stop_i | input | AW | Byte address one past the ring |
| word_mode_i | input | 1 | 1: 2-byte port accesses, 0: 1-byte |
| req_i | input | 1 | Port access strobe, one cycle per access |
| we_i | input | 1 | 1: port write, 0: port read |
| long_i | input | 1 | 4-byte access |
| wdata_i | input | 32 | Write data, little-endian lanes |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| done_o | output | 1 | Completion request pulse |
| addr_o | output | AW | Current local address |
| cnt_o | output | CW | Remaining byte count |

## Verification
Every result of an access or load is registered once, so each one is due at the first rising edge after the request. That covers read data, the valid strobe, the completion pulse, the new address and the new count. The bench drives a request on a falling edge and samples all outputs on the next falling edge, which is after exactly one register stage. It then removes the request, so a done_o pulse is seen in its only cycle. A load vector between accesses also confirms that done_o has fallen again. Results that can only be seen in memory, such as an ignored or dropped write, are checked by reading the affected location back in a later vector.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {XFER_B = 2'd0, XFER_W = 2'd1, XFER_L = 2'd2} xfer_e;

  function automatic logic [2:0] xfer_bytes(xfer_e s);
    case (s)
      XFER_L:  return 3'd4;
      XFER_W:  return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/rdma_addr_ctrl.sv
module rdma_addr_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic [AW-1:0] ring_start_i,
  input  logic [AW-1:0] ring_stop_i,
  input  logic          step_i,
  input  logic [2:0]    nbytes_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q, addr_inc, addr_nxt;
  logic [CW-1:0] cnt_q, nb_c;
  logic          done_q, exhaust;

  assign addr_inc = addr_q + AW'(nbytes_i);
  assign addr_nxt = (addr_inc == ring_stop_i) ? ring_start_i : addr_inc;
  assign nb_c     = CW'(nbytes_i);
  assign exhaust  = (cnt_q <= nb_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (ld_i) begin
      addr_q <= ld_addr_i;
      cnt_q  <= ld_cnt_i;
      done_q <= 1'b0;
    end else if (step_i) begin
      addr_q <= addr_nxt;
      cnt_q  <= exhaust ? '0 : cnt_q - nb_c;
      done_q <= exhaust;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  // R5
  done_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o == '0);
  // R4
  ring_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && step_i && addr_inc == ring_stop_i) |=> addr_o == $past(ring_start_i));
  // R5
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && step_i && cnt_q > nb_c) |=> (cnt_o == $past(cnt_q) - $past(nb_c)) && !done_o);
  // R10
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (addr_o == $past(ld_addr_i)) && (cnt_o == $past(ld_cnt_i)) && !done_o);
endmodule

// File: rtl/rdma_local_mem.sv
module rdma_local_mem #(
  parameter int          AW           = 16,
  parameter int          PMEM_BASE    = 16'h0400,
  parameter int          PMEM_BYTES   = 256,
  parameter logic [47:0] STATION_ADDR = 48'h02_11_22_33_44_55
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    nbytes_i,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          hit_o
);
  localparam int PROM_LOGICAL = 16;
  localparam int PROM_BYTES   = 2 * PROM_LOGICAL;
  localparam int PW           = $clog2(PROM_BYTES);
  localparam int MW           = $clog2(PMEM_BYTES);
  localparam int PMEM_END     = PMEM_BASE + PMEM_BYTES;
  localparam int LANES        = 4;

  function automatic logic [7:0] prom_init(int j);
    int i;
    i = j / 2;
    if (i < 6)                  return STATION_ADDR[47 - 8*i -: 8];
    else if (i == 14 || i == 15) return 8'h57;
    else                        return 8'h00;
  endfunction

  logic [7:0] prom_q [PROM_BYTES];
  logic [7:0] pmem_q [PMEM_BYTES];

  logic [AW:0] a_end;
  logic        prom_hit, pmem_hit;

  assign a_end    = {1'b0, addr_i} + (AW+1)'(nbytes_i);
  assign prom_hit = a_end <= (AW+1)'(PROM_BYTES);
  assign pmem_hit = ({1'b0, addr_i} >= (AW+1)'(PMEM_BASE)) && (a_end <= (AW+1)'(PMEM_END));
  assign hit_o    = prom_hit || pmem_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < PROM_BYTES; j++) prom_q[j] <= prom_init(j);
    end else if (wr_i && prom_hit) begin
      for (int k = 0; k < LANES; k++)
        if (k < int'(nbytes_i)) prom_q[PW'(addr_i + AW'(k))] <= wdata_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && pmem_hit) begin
      for (int k = 0; k < LANES; k++)
        if (k < int'(nbytes_i))
          pmem_q[MW'(addr_i - AW'(PMEM_BASE) + AW'(k))] <= wdata_i[8*k +: 8];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW-1:0] ba;
    logic [7:0]    bv;
    assign ba = addr_i + AW'(k);
    always_comb begin
      if (k >= int'(nbytes_i)) bv = 8'h00;
      else if (prom_hit)       bv = prom_q[PW'(ba)];
      else if (pmem_hit)       bv = pmem_q[MW'(ba - AW'(PMEM_BASE))];
      else                     bv = 8'hFF;
    end
    assign rdata_o[8*k +: 8] = bv;
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int          AW           = 16,
  parameter int          CW           = 16,
  parameter int          PMEM_BASE    = 16'h0400,
  parameter int          PMEM_BYTES   = 256,
  parameter logic [47:0] STATION_ADDR = 48'h02_11_22_33_44_55
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic [AW-1:0] ring_start_i,
  input  logic [AW-1:0] ring_stop_i,
  input  logic          word_mode_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          long_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          rvalid_o,
  output logic          done_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o
);
  import rdma_pkg::*;

  xfer_e         xfer;
  logic [2:0]    nb;
  logic [AW-1:0] eff_addr;
  logic          acc, rd_acc, step, mem_wr, hit;
  logic [31:0]   mem_rdata, rdata_q;
  logic          rvalid_q;

  assign xfer     = long_i ? XFER_L : (word_mode_i ? XFER_W : XFER_B);
  assign nb       = xfer_bytes(xfer);
  assign eff_addr = (xfer == XFER_B) ? addr_o : {addr_o[AW-1:1], 1'b0};
  assign acc      = req_i && !ld_i;
  assign rd_acc   = acc && !we_i;
  // writes stall at zero count, reads never do
  assign step     = acc && !(we_i && cnt_o == '0);
  assign mem_wr   = step && we_i;

  rdma_addr_ctrl #(.AW(AW), .CW(CW)) u_addr_ctrl (
    .clk_i, .rst_ni, .ld_i, .ld_addr_i, .ld_cnt_i, .ring_start_i, .ring_stop_i,
    .step_i(step), .nbytes_i(nb), .addr_o, .cnt_o, .done_o
  );

  rdma_local_mem #(.AW(AW), .PMEM_BASE(PMEM_BASE), .PMEM_BYTES(PMEM_BYTES),
                   .STATION_ADDR(STATION_ADDR)) u_local_mem (
    .clk_i, .rst_ni, .addr_i(eff_addr), .nbytes_i(nb), .wr_i(mem_wr),
    .wdata_i, .rdata_o(mem_rdata), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= mem_rdata;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R6
  ign_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && we_i && cnt_o == '0) |=> $stable(addr_o) && cnt_o == '0 && !done_o);
  // R7
  rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && cnt_o == '0) |=> done_o && cnt_o == '0);
  // R9
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> rvalid_o);
  // R9
  no_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> !rvalid_o);
  // R8
  miss_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !hit) |=> rdata_o[7:0] == 8'hFF);
endmodule

// File: tb/rdma_port_tb.sv
module rdma_port_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_i = 0, req_i = 0, we_i = 0, long_i = 0, word_mode_i = 0;
  logic [15:0] ld_addr_i = '0, ld_cnt_i = '0;
  logic [15:0] ring_start_i = 16'h0400, ring_stop_i = 16'h0410;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        rvalid_o, done_o;
  logic [15:0] addr_o, cnt_o;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  rdma_port u_dut (
    .clk_i(clk), .rst_ni, .ld_i, .ld_addr_i, .ld_cnt_i, .ring_start_i, .ring_stop_i,
    .word_mode_i, .req_i, .we_i, .long_i, .wdata_i, .rdata_o, .rvalid_o, .done_o,
    .addr_o, .cnt_o
  );

  // op: 0 load {addr,cnt}, 1 write, 2 read; sz: 0 byte, 1 word, 2 long
  // {op, sz, data, exp_rdata, exp_addr, exp_cnt, exp_done}
  localparam int NV = 37;
  localparam logic [100:0] VEC [NV] = '{
    {2'd0,2'd0,32'h0407_0001,32'h0,        16'h0407,16'd1, 1'b0},
    {2'd1,2'd0,32'h0000_0011,32'h0,        16'h0408,16'd0, 1'b1},
    {2'd0,2'd0,32'h0400_0006,32'h0,        16'h0400,16'd6, 1'b0},
    {2'd1,2'd1,32'h0000_BEEF,32'h0,        16'h0402,16'd4, 1'b0},
    {2'd1,2'd0,32'h0000_005A,32'h0,        16'h0403,16'd3, 1'b0},
    {2'd1,2'd2,32'h0102_0304,32'h0,        16'h0407,16'd0, 1'b1},
    {2'd1,2'd0,32'h0000_0077,32'h0,        16'h0407,16'd0, 1'b0},
    {2'd0,2'd0,32'h0400_0008,32'h0,        16'h0400,16'd8, 1'b0},
    {2'd2,2'd2,32'h0,        32'h0304_BEEF,16'h0404,16'd4, 1'b0},
    {2'd2,2'd1,32'h0,        32'h0000_0102,16'h0406,16'd2, 1'b0},
    {2'd0,2'd0,32'h0407_0001,32'h0,        16'h0407,16'd1, 1'b0},
    {2'd2,2'd0,32'h0,        32'h0000_0011,16'h0408,16'd0, 1'b1},
    {2'd0,2'd0,32'h0400_0000,32'h0,        16'h0400,16'd0, 1'b0},
    {2'd2,2'd0,32'h0,        32'h0000_00EF,16'h0401,16'd0, 1'b1},
    {2'd0,2'd0,32'h040E_0003,32'h0,        16'h040E,16'd3, 1'b0},
    {2'd1,2'd1,32'h0000_CAFE,32'h0,        16'h0400,16'd1, 1'b0},
    {2'd2,2'd0,32'h0,        32'h0000_00EF,16'h0401,16'd0, 1'b1},
    {2'd0,2'd0,32'h040E_0002,32'h0,        16'h040E,16'd2, 1'b0},
    {2'd2,2'd1,32'h0,        32'h0000_CAFE,16'h0400,16'd0, 1'b1},
    {2'd0,2'd0,32'h0100_0004,32'h0,        16'h0100,16'd4, 1'b0},
    {2'd2,2'd1,32'h0,        32'h0000_FFFF,16'h0102,16'd2, 1'b0},
    {2'd2,2'd2,32'h0,        32'hFFFF_FFFF,16'h0106,16'd0, 1'b1},
    {2'd0,2'd0,32'h0200_0001,32'h0,        16'h0200,16'd1, 1'b0},
    {2'd2,2'd0,32'h0,        32'h0000_00FF,16'h0201,16'd0, 1'b1},
    {2'd0,2'd0,32'h04FE_0004,32'h0,        16'h04FE,16'd4, 1'b0},
    {2'd2,2'd2,32'h0,        32'hFFFF_FFFF,16'h0502,16'd0, 1'b1},
    {2'd0,2'd0,32'h0000_0020,32'h0,        16'h0000,16'd32,1'b0},
    {2'd2,2'd2,32'h0,        32'h1111_0202,16'h0004,16'd28,1'b0},
    {2'd2,2'd1,32'h0,        32'h0000_2222,16'h0006,16'd26,1'b0},
    {2'd0,2'd0,32'h001C_0002,32'h0,        16'h001C,16'd2, 1'b0},
    {2'd2,2'd1,32'h0,        32'h0000_5757,16'h001E,16'd0, 1'b1},
    {2'd0,2'd0,32'h001E_0004,32'h0,        16'h001E,16'd4, 1'b0},
    {2'd2,2'd2,32'h0,        32'hFFFF_FFFF,16'h0022,16'd0, 1'b1},
    {2'd0,2'd0,32'h000A_0001,32'h0,        16'h000A,16'd1, 1'b0},
    {2'd2,2'd0,32'h0,        32'h0000_0055,16'h000B,16'd0, 1'b1},
    {2'd0,2'd0,32'h0005_0002,32'h0,        16'h0005,16'd2, 1'b0},
    {2'd2,2'd1,32'h0,        32'h0000_2222,16'h0007,16'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operation at a falling edge, sample at the next falling edge
  task automatic cyc(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    ld_i        = (op == 2'd0);
    ld_addr_i   = d[31:16];
    ld_cnt_i    = d[15:0];
    req_i       = (op != 2'd0);
    we_i        = (op == 2'd1);
    long_i      = (sz == 2'd2);
    word_mode_i = (sz == 2'd1);
    wdata_i     = d;
    @(negedge clk);
    ld_i  = 1'b0;
    req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(addr_o == 16'h0 && cnt_o == 16'h0, "R1 reset addr/count", {addr_o, cnt_o}, 32'h0);
    chk(!done_o && !rvalid_o, "R1 reset strobes", {30'h0, done_o, rvalid_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [100:0] v;
      v = VEC[i];
      cyc(v[100:99], v[98:97], v[96:65]);
      if (v[100:99] == 2'd2)
        chk(rdata_o == v[64:33], $sformatf("R2 R3 R8 R1 vec%0d rdata", i), rdata_o, v[64:33]);
      chk(rvalid_o == (v[100:99] == 2'd2), $sformatf("R9 vec%0d rvalid", i), {31'h0, rvalid_o},
          {31'h0, v[100:99] == 2'd2});
      chk(addr_o == v[32:17], $sformatf("R3 R4 R6 R10 vec%0d addr", i), {16'h0, addr_o}, {16'h0, v[32:17]});
      chk(cnt_o == v[16:1], $sformatf("R5 R6 R7 R10 vec%0d count", i), {16'h0, cnt_o}, {16'h0, v[16:1]});
      chk(done_o == v[0], $sformatf("R5 R7 vec%0d done", i), {31'h0, done_o}, {31'h0, v[0]});
    end

    // R8: a long write straddling the PROM end is dropped
    cyc(2'd0, 2'd0, 32'h001E_0004);
    cyc(2'd1, 2'd2, 32'hDEAD_BEEF);
    chk(addr_o == 16'h0022, "R8 missed write still advances", {16'h0, addr_o}, 32'h0022);
    cyc(2'd0, 2'd0, 32'h001E_0001);
    cyc(2'd2, 2'd0, 32'h0);
    chk(rdata_o == 32'h57, "R8 missed write left PROM", rdata_o, 32'h57);

    // R10: load wins over a same-cycle request
    @(negedge clk);
    ld_i = 1'b1; ld_addr_i = 16'h0400; ld_cnt_i = 16'd5;
    req_i = 1'b1; we_i = 1'b0; long_i = 1'b0; word_mode_i = 1'b0;
    @(negedge clk);
    ld_i = 1'b0; req_i = 1'b0;
    chk(addr_o == 16'h0400 && cnt_o == 16'd5 && !rvalid_o, "R10 load priority",
        {addr_o, cnt_o}, {16'h0400, 16'd5});

    // R1: PROM write, then reset restores contents
    cyc(2'd0, 2'd0, 32'h0000_0001);
    cyc(2'd1, 2'd0, 32'h0000_00AA);
    cyc(2'd0, 2'd0, 32'h0000_0001);
    cyc(2'd2, 2'd0, 32'h0);
    chk(rdata_o == 32'hAA, "R8 PROM write hit", rdata_o, 32'hAA);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(addr_o == 16'h0 && cnt_o == 16'h0 && !done_o && !rvalid_o, "R1 mid-run reset",
        {addr_o, cnt_o}, 32'h0);
    rst_ni = 1'b1;
    cyc(2'd0, 2'd0, 32'h0000_0001);
    cyc(2'd2, 2'd0, 32'h0);
    chk(rdata_o == 32'h02, "R1 PROM restored by reset", rdata_o, 32'h02);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule